// File: doc/BRIEF.md
# Asynchronous Audio Rate Feedback Generator

This block lives in the local audio clock domain of a USB audio playback device whose sample clock is free-running and never locked to the host. It measures how many master-clock cycles pass between successive microframe start strobes. Those gaps are summed over a power-of-two window of microframes, and the sum is turned into the number of audio samples the local clock consumes per microframe. A master clock of 24.576 MHz with 512 cycles per sample gives 48 kHz, and an 8 kHz microframe rate gives a nominal result of exactly 6.0.

The result is an unsigned fixed-point word with 16 integer and 16 fraction bits. A one-cycle strobe marks each new value. Device firmware or a feedback endpoint reports this value to the host, which then sends more or fewer samples per packet so that its average rate follows the local clock. The window restarts after every result, so the value keeps tracking slow drift between the two clocks. Each result is limited to one sample above or below nominal, which keeps a single bad measurement from steering the host far off.

If the strobes stop for longer than twice the nominal microframe interval, the block keeps the last good value and raises a stale flag. It drops the partial window and starts measuring again at the next strobe.

Top module: `rate_feedback_gen`

## Requirements
- R1: While reset is held and right after it, the output word equals the nominal value (NOM_PERIOD / 2^LOG2_CPS in 16.16 format, 0x0006_0000 for the defaults), the update strobe is low and the stale flag is low.
- R2: The first microframe strobe after reset, or after a stale event, only arms the measurement. The time before that strobe is never counted as an interval.
- R3: An interval is the number of clock cycles from one strobe to the next. After every 2^LOG2_FRAMES intervals the block raises the update strobe for exactly one cycle, so there is exactly one update per window.
- R4: On an update the output word is S * 2^16 / (2^LOG2_FRAMES * 2^LOG2_CPS), where S is the sum of the window's intervals. Bits 31:16 hold the whole samples and bits 15:0 hold the fraction.
- R5: A computed value above nominal plus 1.0 (nominal + 0x0001_0000) is output as exactly nominal plus 1.0.
- R6: A computed value below nominal minus 1.0 is output as exactly nominal minus 1.0.
- R7: When no strobe arrives for more than 2 * NOM_PERIOD cycles after an armed strobe, the stale flag goes high, the output word keeps its last value, no update strobe is issued, and the intervals already collected in the open window are discarded.
- R8: A gap of exactly 2 * NOM_PERIOD cycles counts as a valid interval and does not raise the stale flag.
- R9: The stale flag stays high until the next update strobe, and it is low in the cycle that strobe is high.
- R10: The output word changes only in a cycle where the update strobe is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local audio master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sof | input | 1 | One-cycle microframe start strobe, already synchronised to clk |
| fb_word | output | 32 | Samples per microframe, unsigned 16.16 |
| fb_strobe | output | 1 | High for one cycle when fb_word takes a new value |
| fb_stale | output | 1 | High after a strobe gap longer than twice nominal, until the next update |

## Verification
The bench drives windows of equal gaps at the nominal period and one cycle above it, and a mixed window of four different gaps. Together they show that the output is the scaled sum of the gaps and not one sampled gap. Windows well above and well below nominal check that each side saturates at its own limit. A window that contains a gap of exactly twice nominal checks the stale boundary from the valid side. A long silence after a partial window of large gaps shows whether those gaps are really discarded: if they are kept, the next result moves off 6.0. A long lead-in before the first strobe shows whether the arming strobe is wrongly counted as an interval.

// File: rtl/rfb_pkg.sv
package rfb_pkg;
    localparam int FB_W    = 32;
    localparam int FB_FRAC = 16;
    localparam int WIDE_W  = 48;

    typedef logic [FB_W-1:0]   fb_word_t;
    typedef logic [WIDE_W-1:0] wide_t;

    // Saturate a wide measurement into the window [lo, hi].
    function automatic fb_word_t clamp_word(input wide_t v, input fb_word_t lo, input fb_word_t hi);
        if (v > wide_t'(hi)) return hi;
        if (v < wide_t'(lo)) return lo;
        return v[FB_W-1:0];
    endfunction
endpackage

// File: rtl/rfb_sof_meter.sv
module rfb_sof_meter #(
    parameter int NOM_PERIOD = 3072,
    parameter int CNT_W      = $clog2(2*NOM_PERIOD+1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sof,
    output logic             ivl_valid,
    output logic [CNT_W-1:0] ivl,
    output logic             gap_abort
);
    localparam int LIMIT = 2 * NOM_PERIOD;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             armed;
        logic             ivl_valid;
        logic [CNT_W-1:0] ivl;
        logic             abort;
    } meter_t;

    meter_t m_d, m_q;

    always_comb begin
        m_d           = m_q;
        m_d.ivl_valid = 1'b0;
        m_d.abort     = 1'b0;
        if (m_q.cnt != CNT_W'(LIMIT - 1)) m_d.cnt = m_q.cnt + 1'b1;
        if (sof) begin
            m_d.cnt   = '0;
            m_d.armed = 1'b1;
            if (m_q.armed) begin
                m_d.ivl_valid = 1'b1;
                m_d.ivl       = m_q.cnt + 1'b1;
            end
        end else if (m_q.armed && m_q.cnt == CNT_W'(LIMIT - 1)) begin
            m_d.armed = 1'b0;
            m_d.abort = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) m_q <= '0;
        else        m_q <= m_d;
    end

    assign ivl_valid = m_q.ivl_valid;
    assign ivl       = m_q.ivl;
    assign gap_abort = m_q.abort;

    AST_ARM_BEFORE_MEASURE: assert property (@(posedge clk) disable iff (!rst_n)
        m_q.ivl_valid |-> $past(m_q.armed)); // R2
    AST_INTERVAL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        m_q.ivl_valid |-> (m_q.ivl >= CNT_W'(1) && m_q.ivl <= CNT_W'(LIMIT))); // R8
    AST_ABORT_NO_SOF: assert property (@(posedge clk) disable iff (!rst_n)
        m_q.abort |-> (!$past(sof) && !m_q.armed)); // R7
endmodule

// File: rtl/rfb_frame_accum.sv
module rfb_frame_accum #(
    parameter int CNT_W       = 13,
    parameter int LOG2_FRAMES = 3,
    parameter int SUM_W       = CNT_W + LOG2_FRAMES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ivl_valid,
    input  logic [CNT_W-1:0] ivl,
    input  logic             abort,
    output logic             sum_valid,
    output logic [SUM_W-1:0] sum
);
    typedef struct packed {
        logic [SUM_W-1:0]       acc;
        logic [LOG2_FRAMES-1:0] frames;
        logic                   out_valid;
        logic [SUM_W-1:0]       out_sum;
    } accum_t;

    accum_t a_d, a_q;
    logic [SUM_W-1:0] acc_next;

    always_comb begin
        a_d           = a_q;
        a_d.out_valid = 1'b0;
        acc_next      = a_q.acc + SUM_W'(ivl);
        if (abort) begin
            a_d.acc    = '0;
            a_d.frames = '0;
        end else if (ivl_valid) begin
            if (&a_q.frames) begin
                a_d.out_valid = 1'b1;
                a_d.out_sum   = acc_next;
                a_d.acc       = '0;
                a_d.frames    = '0;
            end else begin
                a_d.acc    = acc_next;
                a_d.frames = a_q.frames + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) a_q <= '0;
        else        a_q <= a_d;
    end

    assign sum_valid = a_q.out_valid;
    assign sum       = a_q.out_sum;

    AST_ABORT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(abort) |-> (a_q.acc == '0 && a_q.frames == '0)); // R7
    AST_SUM_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        a_q.out_valid |=> !a_q.out_valid); // R3
endmodule

// File: rtl/rfb_scale_clamp.sv
module rfb_scale_clamp
    import rfb_pkg::*;
#(
    parameter int       SUM_W  = 16,
    parameter int       SHIFT  = 4,
    parameter fb_word_t NOM_FB = 32'h0006_0000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sum_valid,
    input  logic [SUM_W-1:0] sum,
    input  logic             abort,
    output fb_word_t         fb,
    output logic             fb_valid,
    output logic             stale
);
    localparam int       SH_L   = (SHIFT > 0) ? SHIFT : 0;
    localparam int       SH_R   = (SHIFT < 0) ? -SHIFT : 0;
    localparam fb_word_t ONE    = fb_word_t'(1) << FB_FRAC;
    localparam fb_word_t LIM_HI = NOM_FB + ONE;
    localparam fb_word_t LIM_LO = NOM_FB - ONE;

    typedef struct packed {
        fb_word_t fb;
        logic     valid;
        logic     stale;
    } out_t;

    out_t  o_d, o_q;
    wide_t scaled;

    always_comb begin
        scaled     = (wide_t'(sum) << SH_L) >> SH_R;
        o_d        = o_q;
        o_d.valid  = 1'b0;
        if (sum_valid) begin
            o_d.fb    = clamp_word(scaled, LIM_LO, LIM_HI);
            o_d.valid = 1'b1;
            o_d.stale = 1'b0;
        end
        if (abort) o_d.stale = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) o_q <= '{fb: NOM_FB, valid: 1'b0, stale: 1'b0};
        else        o_q <= o_d;
    end

    assign fb       = o_q.fb;
    assign fb_valid = o_q.valid;
    assign stale    = o_q.stale;

    AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
        !o_q.valid |-> $stable(o_q.fb)); // R10
    AST_CLAMP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        o_q.fb <= LIM_HI); // R5
    AST_CLAMP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        o_q.fb >= LIM_LO); // R6
    AST_STALE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        o_q.valid |-> !o_q.stale); // R9
endmodule

// File: rtl/rate_feedback_gen.sv
module rate_feedback_gen
    import rfb_pkg::*;
#(
    parameter int NOM_PERIOD  = 3072,
    parameter int LOG2_CPS    = 9,
    parameter int LOG2_FRAMES = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sof,
    output logic [31:0] fb_word,
    output logic        fb_strobe,
    output logic        fb_stale
);
    localparam int       CNT_W  = $clog2(2*NOM_PERIOD+1);
    localparam int       SUM_W  = CNT_W + LOG2_FRAMES;
    localparam int       SHIFT  = FB_FRAC - LOG2_FRAMES - LOG2_CPS;
    localparam fb_word_t NOM_FB = (fb_word_t'(NOM_PERIOD) << FB_FRAC) >> LOG2_CPS;

    logic             ivl_valid, gap_abort, sum_valid;
    logic [CNT_W-1:0] ivl;
    logic [SUM_W-1:0] sum;

    rfb_sof_meter #(.NOM_PERIOD(NOM_PERIOD), .CNT_W(CNT_W)) u_meter (
        .clk(clk), .rst_n(rst_n), .sof(sof),
        .ivl_valid(ivl_valid), .ivl(ivl), .gap_abort(gap_abort)
    );

    rfb_frame_accum #(.CNT_W(CNT_W), .LOG2_FRAMES(LOG2_FRAMES), .SUM_W(SUM_W)) u_accum (
        .clk(clk), .rst_n(rst_n), .ivl_valid(ivl_valid), .ivl(ivl),
        .abort(gap_abort), .sum_valid(sum_valid), .sum(sum)
    );

    rfb_scale_clamp #(.SUM_W(SUM_W), .SHIFT(SHIFT), .NOM_FB(NOM_FB)) u_scale (
        .clk(clk), .rst_n(rst_n), .sum_valid(sum_valid), .sum(sum),
        .abort(gap_abort), .fb(fb_word), .fb_valid(fb_strobe), .stale(fb_stale)
    );
endmodule

// File: tb/sim_rate_feedback_gen.sv
module sim_rate_feedback_gen;
    localparam int CLK_PERIOD = 10;
    localparam int NOM        = 96;
    localparam int L2CPS      = 4;
    localparam int L2FR       = 2;
    localparam logic [31:0] NOM_FB = 32'h0006_0000;
    localparam logic [31:0] HI     = 32'h0007_0000;
    localparam logic [31:0] LO     = 32'h0005_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sof = 1'b0;
    logic [31:0] fb_word;
    logic        fb_strobe, fb_stale;

    int checks = 0;
    int errors = 0;
    int drift_errs = 0;
    bit done = 1'b0;
    logic [31:0] exp_q[$];
    logic [31:0] prev_word;

    always #(CLK_PERIOD/2) clk = ~clk;

    rate_feedback_gen #(.NOM_PERIOD(NOM), .LOG2_CPS(L2CPS), .LOG2_FRAMES(L2FR)) u0 (
        .clk(clk), .rst_n(rst_n), .sof(sof),
        .fb_word(fb_word), .fb_strobe(fb_strobe), .fb_stale(fb_stale)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Strobe high exactly gap cycles after the previous strobe.
    task automatic send(input int gap);
        repeat (gap - 1) @(negedge clk) sof = 1'b0;
        @(negedge clk) sof = 1'b1;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk) sof = 1'b0;
    endtask

    // R4, R5, R6: expected word = sum * 2^16 / (4 * 16), saturated at nominal +/- 1.0
    task automatic frame(input int g0, input int g1, input int g2, input int g3);
        longint s = longint'(g0 + g1 + g2 + g3) * 1024;
        logic [31:0] e;
        if (s > longint'(HI))      e = HI;
        else if (s < longint'(LO)) e = LO;
        else                       e = s[31:0];
        exp_q.push_back(e);
        send(g0); send(g1); send(g2); send(g3);
    endtask

    // Scoreboard monitor: pops one expected word per update strobe.
    always @(negedge clk) begin
        if (rst_n) begin
            if (fb_strobe) begin
                if (exp_q.size() == 0) check("R3 unexpected update", fb_word, 32'hxxxx_xxxx);
                else check("R4 update value", fb_word, exp_q.pop_front());
                check("R9 stale low on update", {31'b0, fb_stale}, 32'd0);
            end else if (fb_word !== prev_word) begin
                drift_errs++;
            end
        end
        prev_word = fb_word;
    end

    initial begin
        repeat (4) @(negedge clk);
        check("R1 reset word", fb_word, NOM_FB);
        check("R1 reset strobe", {31'b0, fb_strobe}, 32'd0);
        check("R1 reset stale", {31'b0, fb_stale}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 word after reset", fb_word, NOM_FB);

        send(50);                         // R2: arming strobe only
        frame(96, 96, 96, 96);            // R2 R3 R4 nominal 6.0
        frame(97, 97, 97, 97);            // R4 6.0625
        frame(95, 96, 97, 98);            // R4 mixed
        frame(120, 120, 120, 120);        // R5 clamp high
        frame(70, 70, 70, 70);            // R6 clamp low
        frame(192, 96, 96, 96);           // R8 gap of exactly twice nominal
        idle(5);
        check("R8 no stale at boundary gap", {31'b0, fb_stale}, 32'd0);

        send(120); send(120);             // partial window, then silence
        idle(300);
        check("R7 stale raised", {31'b0, fb_stale}, 32'd1);
        check("R7 word held", fb_word, HI);
        check("R7 no pending update", exp_q.size(), 32'd0);

        send(40);                         // R2 re-arm after stale
        frame(96, 96, 96, 96);            // R7 partial window discarded -> 6.0
        idle(1);
        check("R9 stale still high before update", {31'b0, fb_stale}, 32'd1);
        idle(10);
        check("R9 stale cleared by update", {31'b0, fb_stale}, 32'd0);
        check("R3 all updates seen", exp_q.size(), 32'd0);
        check("R10 word changed only on strobe", drift_errs, 32'd0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule